// File: doc/BRIEF.md
# Dual-Master Bus Ownership Controller

This block decides which of two upstream bus masters drives a shared downstream two-wire bus. Only one master can be connected at a time. Each master has a request strobe to take ownership and a release strobe to give it up. Either master can take the bus at any time, so a master that has failed or been removed never locks the other one out. When ownership moves, the block first opens both pass switches and raises a "switch pending" flag. An external recovery or initialization sequencer can then settle the downstream bus. The new connection closes only once that sequencer reports the bus ready.

Each master has its own active-low interrupt line, and two sources can raise it. The first is a notice that the master has just lost ownership. The second is a forwarded copy of the single downstream interrupt input. Every source on every master has its own mask bit. A raised interrupt stays asserted until its master acknowledges it. A parameter picks the state after reset: either master 0 connected, or nothing connected. The active-low reset returns all selection and mask state to that default.

Top module: `bus_owner_ctrl`

## Requirements
- R1: At no time is more than one bit of `sel_o` set.
- R2: After reset with `PWRUP_M0`=1, `sel_o`=2'b01, `switch_pend_o`=0 and both interrupt lines are high. With `PWRUP_M0`=0, `sel_o`=2'b00.
- R3: A request from a master that is not the current target is accepted at the next clock edge. After that edge `sel_o`=2'b00 and `switch_pend_o`=1.
- R4: While `switch_pend_o`=1, `sel_o` stays 2'b00 until a clock edge samples `dn_ready_i`=1. After that edge `sel_o` is the one-hot code of the new owner (bit 0 for master 0, bit 1 for master 1) and `switch_pend_o`=0.
- R5: If both masters request in the same cycle, master 0 becomes the target and the request from master 1 is dropped.
- R6: A release from the current target disconnects the bus, with `sel_o`=00 and `switch_pend_o`=0, and leaves no owner. A release from the other master has no effect.
- R7: When the target moves away from a master, that master's line `up_int_n_o[m]` goes low after the same edge, unless its lost-ownership mask bit is set.
- R8: A low level on `dn_int_n_i` sampled at an edge drives both `up_int_n_o` bits low after that edge. This does not happen on a master whose forwarding mask bit is set.
- R9: An interrupt stays low until `ack_i[m]` is sampled high. If a source is active in that same cycle, the set wins over the acknowledge.
- R10: A pulse on `mask_we_i[m]` loads `mask_wdata_i[2m+1:2m]` as that master's masks. Bit 2m masks the lost-ownership source and bit 2m+1 masks forwarding, and 1 means masked. A masked source never pulls the line low. All masks are 0 after reset.
- R11: Asserting `rst_n` low in the middle of operation restores the power-up selection, clears the pending state and interrupts, and clears all masks.
- R12: A request from the current target changes nothing and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 2 | Ownership request strobe, one bit per master |
| rel_i | input | 2 | Ownership release strobe, one bit per master |
| ack_i | input | 2 | Interrupt acknowledge strobe, one bit per master |
| mask_we_i | input | 2 | Mask write strobe, one bit per master |
| mask_wdata_i | input | 4 | Mask values, two bits per master |
| dn_int_n_i | input | 1 | Downstream interrupt, active low |
| dn_ready_i | input | 1 | Downstream bus settled, new connection may close |
| sel_o | output | 2 | Pass-switch enables, one-hot or zero |
| switch_pend_o | output | 1 | Ownership change waiting for `dn_ready_i` |
| up_int_n_o | output | 2 | Upstream interrupt lines, active low, level |

## Verification
The hardest situation to reach is a handover to a master whose lost-ownership notice is masked. That case is only observable after the bus has been passed back and forth, so the stimulus first hands ownership to master 0 and writes the mask for master 0. It then lets master 1 take the bus and checks that master 0's line stays high. Two further cases need a precise cycle: a same-cycle tie between requests, and an acknowledge that coincides with an active downstream interrupt. The stimulus drives each of these on one exact cycle and checks the following edge.

// File: rtl/bus_owner_pkg.sv
package bus_owner_pkg;
    localparam int NUM_MST  = 2;
    localparam int SRC_NUM  = 2;
    localparam int MSK_LOST = 0;
    localparam int MSK_FWD  = 1;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_M0   = 2'd1,
        OWN_M1   = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e               tgt;
        logic [NUM_MST-1:0]   sel;
        logic                 pend;
    } arb_st_t;

    typedef struct packed {
        logic [SRC_NUM-1:0]   mask;
        logic                 lost;
        logic                 fwd;
    } irq_st_t;

    function automatic logic [NUM_MST-1:0] owner_onehot(input owner_e o);
        logic [NUM_MST-1:0] r;
        r = '0;
        if (o == OWN_M0) r[0] = 1'b1;
        if (o == OWN_M1) r[1] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/bus_owner_arb.sv
module bus_owner_arb
    import bus_owner_pkg::*;
#(
    parameter bit PWRUP_M0 = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MST-1:0] req_i,
    input  logic [NUM_MST-1:0] rel_i,
    input  logic               dn_ready_i,
    output logic [NUM_MST-1:0] sel_o,
    output logic               pend_o,
    output logic [NUM_MST-1:0] lost_o
);
    localparam owner_e RST_TGT = PWRUP_M0 ? OWN_M0 : OWN_NONE;

    arb_st_t st_q, st_d;
    owner_e  win;

    always_comb begin
        if (req_i[0])      win = OWN_M0;
        else if (req_i[1]) win = OWN_M1;
        else               win = OWN_NONE;
    end

    always_comb begin
        st_d   = st_q;
        lost_o = '0;
        if (win != OWN_NONE && win != st_q.tgt) begin
            lost_o[0] = (st_q.tgt == OWN_M0);
            lost_o[1] = (st_q.tgt == OWN_M1);
            st_d.tgt  = win;
            st_d.sel  = '0;
            st_d.pend = 1'b1;
        end else if ((st_q.tgt == OWN_M0 && rel_i[0]) ||
                     (st_q.tgt == OWN_M1 && rel_i[1])) begin
            st_d.tgt  = OWN_NONE;
            st_d.sel  = '0;
            st_d.pend = 1'b0;
        end else if (st_q.pend && dn_ready_i) begin
            st_d.sel  = owner_onehot(st_q.tgt);
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tgt  <= RST_TGT;
            st_q.sel  <= owner_onehot(RST_TGT);
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o  = st_q.sel;
    assign pend_o = st_q.pend;

    AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o)); // R1
    AST_PEND_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o |-> (sel_o == '0)); // R3
    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == '0 && !dn_ready_i) |=> (sel_o == '0)); // R4
    AST_TIE_M0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == 2'b11 && st_q.tgt != OWN_M0) |=> (pend_o && lost_o == '0 && !req_i[1]) or (pend_o)); // R5
endmodule

// File: rtl/bus_owner_irq.sv
module bus_owner_irq
    import bus_owner_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lost_evt_i,
    input  logic               dn_act_i,
    input  logic               ack_i,
    input  logic               mask_we_i,
    input  logic [SRC_NUM-1:0] mask_wdata_i,
    output logic               int_n_o
);
    irq_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.lost = (st_q.lost & ~ack_i) | (lost_evt_i & ~st_q.mask[MSK_LOST]);
        st_d.fwd  = (st_q.fwd  & ~ack_i) | (dn_act_i   & ~st_q.mask[MSK_FWD]);
        if (mask_we_i) st_d.mask = mask_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign int_n_o = ~((st_q.lost & ~st_q.mask[MSK_LOST]) |
                       (st_q.fwd  & ~st_q.mask[MSK_FWD]));

    AST_LOST_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_evt_i && !st_q.mask[MSK_LOST] && !mask_we_i) |=> !int_n_o); // R7
    AST_FWD_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_act_i && !st_q.mask[MSK_FWD] && !mask_we_i) |=> !int_n_o); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !lost_evt_i && !dn_act_i) |=> int_n_o); // R9
    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '1 && !mask_we_i) |=> int_n_o); // R10
endmodule

// File: rtl/bus_owner_ctrl.sv
module bus_owner_ctrl
    import bus_owner_pkg::*;
#(
    parameter bit PWRUP_M0 = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_i,
    input  logic [1:0] rel_i,
    input  logic [1:0] ack_i,
    input  logic [1:0] mask_we_i,
    input  logic [3:0] mask_wdata_i,
    input  logic       dn_int_n_i,
    input  logic       dn_ready_i,
    output logic [1:0] sel_o,
    output logic       switch_pend_o,
    output logic [1:0] up_int_n_o
);
    logic [NUM_MST-1:0] lost;
    logic               dn_act;

    assign dn_act = ~dn_int_n_i;

    bus_owner_arb #(.PWRUP_M0(PWRUP_M0)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .rel_i      (rel_i),
        .dn_ready_i (dn_ready_i),
        .sel_o      (sel_o),
        .pend_o     (switch_pend_o),
        .lost_o     (lost)
    );

    for (genvar m = 0; m < NUM_MST; m++) begin : g_irq
        bus_owner_irq u_irq (
            .clk          (clk),
            .rst_n        (rst_n),
            .lost_evt_i   (lost[m]),
            .dn_act_i     (dn_act),
            .ack_i        (ack_i[m]),
            .mask_we_i    (mask_we_i[m]),
            .mask_wdata_i (mask_wdata_i[m*SRC_NUM +: SRC_NUM]),
            .int_n_o      (up_int_n_o[m])
        );
    end

    AST_OWNER_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == 2'b01 && sel_o == 2'b01 && rel_i == '0 && dn_int_n_i) |=> (sel_o == 2'b01 && !switch_pend_o)); // R12
endmodule

// File: tb/tb_bus_owner_ctrl.sv
`timescale 1ns/1ps
module tb_bus_owner_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] req = '0, rel = '0, ack = '0, mwe = '0;
    logic [3:0] mwd = '0;
    logic       dni = 1'b1, rdy = 1'b0;
    logic [1:0] sel, intn, sel_nc, intn_nc;
    logic       pend, pend_nc;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    bus_owner_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .rel_i(rel), .ack_i(ack),
        .mask_we_i(mwe), .mask_wdata_i(mwd), .dn_int_n_i(dni), .dn_ready_i(rdy),
        .sel_o(sel), .switch_pend_o(pend), .up_int_n_o(intn));

    bus_owner_ctrl #(.PWRUP_M0(1'b0)) dut_nc (
        .clk(clk), .rst_n(rst_n), .req_i(2'b00), .rel_i(2'b00), .ack_i(2'b00),
        .mask_we_i(2'b00), .mask_wdata_i(4'b0000), .dn_int_n_i(1'b1), .dn_ready_i(1'b0),
        .sel_o(sel_nc), .switch_pend_o(pend_nc), .up_int_n_o(intn_nc));

    task automatic check(input logic [4:0] act, input logic [4:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual sel/pend/int=%b expected %b", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item after each edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) check({sel, pend, intn}, exp_q.pop_front(), tag_q.pop_front());
    end

    // driver: apply inputs for one cycle and queue the outcome expected after the edge
    task automatic step(input logic [1:0] r, input logic [1:0] rl, input logic [1:0] ak,
                        input logic [1:0] we, input logic [3:0] wd, input logic dn, input logic rd,
                        input logic [1:0] es, input logic ep, input logic [1:0] ei, input string tag);
        @(negedge clk);
        req = r; rel = rl; ack = ak; mwe = we; mwd = wd; dni = dn; rdy = rd;
        exp_q.push_back({es, ep, ei});
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        req = '0; rel = '0; ack = '0; mwe = '0; mwd = '0; dni = 1'b1; rdy = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        check({sel, pend, intn}, 5'b01_0_11, "R2 reset default ch0");
        check({sel_nc, pend_nc, intn_nc}, 5'b00_0_11, "R2 reset no channel");
        step(2'b00, 2'b00, 2'b00, 2'b00, 4'h0, 1'b1, 1'b0, 2'b01, 1'b0, 2'b11, "R2 idle hold");
        step(2'b10, 2'b00, 2'b00, 2'b00, 4'h0, 1'b1, 1'b0, 2'b00, 1'b1, 2'b10, "R3 R7 m1 takes");
        step(2'b00, 2'b00, 2'b00, 2'b00, 4'h0, 1'b1, 1'b0, 2'b00, 1'b1, 2'b10, "R4 wait ready");
        step(2'b00, 2'b00, 2'b00, 2'b00, 4'h0, 1'b1, 1'b1, 2'b10, 1'b0, 2'b10, "R4 connect m1");
        step(2'b00, 2'b00, 2'b01, 2'b00, 4'h0, 1'b1, 1'b0, 2'b10, 1'b0, 2'b11, "R9 ack m0");
        step(2'b10, 2'b00, 2'b00, 2'b00, 4'h0, 1'b1, 1'b0, 2'b10, 1'b0, 2'b11, "R12 owner request");
        step(2'b11, 2'b00, 2'b00, 2'b00, 4'h0, 1'b1, 1'b0, 2'b00, 1'b1, 2'b01, "R5 tie m0 wins");
        step(2'b00, 2'b00, 2'b00, 2'b00, 4'h0, 1'b1, 1'b1, 2'b01, 1'b0, 2'b01, "R4 R5 connect m0");
        step(2'b00, 2'b00, 2'b10, 2'b00, 4'h0, 1'b1, 1'b0, 2'b01, 1'b0, 2'b11, "R9 ack m1");
        step(2'b00, 2'b10, 2'b00, 2'b00, 4'h0, 1'b1, 1'b0, 2'b01, 1'b0, 2'b11, "R6 foreign release");
        step(2'b00, 2'b01, 2'b00, 2'b00, 4'h0, 1'b1, 1'b0, 2'b00, 1'b0, 2'b11, "R6 owner release");
        step(2'b10, 2'b00, 2'b00, 2'b00, 4'h0, 1'b1, 1'b0, 2'b00, 1'b1, 2'b11, "R3 take from none");
        step(2'b00, 2'b00, 2'b00, 2'b00, 4'h0, 1'b1, 1'b1, 2'b10, 1'b0, 2'b11, "R4 connect m1 again");
        step(2'b00, 2'b00, 2'b00, 2'b01, 4'b0001, 1'b1, 1'b0, 2'b10, 1'b0, 2'b11, "R10 mask m0 lost");
        step(2'b01, 2'b00, 2'b00, 2'b00, 4'h0, 1'b1, 1'b0, 2'b00, 1'b1, 2'b01, "R7 m1 loses");
        step(2'b00, 2'b00, 2'b00, 2'b00, 4'h0, 1'b1, 1'b1, 2'b01, 1'b0, 2'b01, "R4 connect m0");
        step(2'b00, 2'b00, 2'b10, 2'b00, 4'h0, 1'b1, 1'b0, 2'b01, 1'b0, 2'b11, "R9 ack m1");
        step(2'b10, 2'b00, 2'b00, 2'b00, 4'h0, 1'b1, 1'b0, 2'b00, 1'b1, 2'b11, "R10 masked lost quiet");
        step(2'b00, 2'b00, 2'b00, 2'b00, 4'h0, 1'b1, 1'b1, 2'b10, 1'b0, 2'b11, "R4 connect m1");
        step(2'b00, 2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 2'b10, 1'b0, 2'b00, "R8 forward both");
        step(2'b00, 2'b00, 2'b00, 2'b00, 4'h0, 1'b1, 1'b0, 2'b10, 1'b0, 2'b00, "R9 level held");
        step(2'b00, 2'b00, 2'b11, 2'b00, 4'h0, 1'b1, 1'b0, 2'b10, 1'b0, 2'b11, "R9 ack both");
        step(2'b00, 2'b00, 2'b11, 2'b00, 4'h0, 1'b0, 1'b0, 2'b10, 1'b0, 2'b00, "R9 set beats ack");
        step(2'b00, 2'b00, 2'b11, 2'b00, 4'h0, 1'b1, 1'b0, 2'b10, 1'b0, 2'b11, "R9 clear after");
        step(2'b00, 2'b00, 2'b00, 2'b10, 4'b1000, 1'b1, 1'b0, 2'b10, 1'b0, 2'b11, "R10 mask m1 fwd");
        step(2'b00, 2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 2'b10, 1'b0, 2'b10, "R8 R10 fwd masked m1");
        step(2'b00, 2'b00, 2'b01, 2'b00, 4'h0, 1'b1, 1'b0, 2'b10, 1'b0, 2'b11, "R9 ack m0 fwd");
        @(negedge clk);
        do_reset();
        check({sel, pend, intn}, 5'b01_0_11, "R11 mid-run reset state");
        step(2'b00, 2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 2'b01, 1'b0, 2'b00, "R11 masks cleared");
        step(2'b00, 2'b00, 2'b11, 2'b00, 4'h0, 1'b1, 1'b0, 2'b01, 1'b0, 2'b11, "R11 ack after reset");
        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule